// File: doc/BRIEF.md
# Light Dimming Pulse-Width Modulator

This block drives one light output from a fast master clock with a fixed-period pulse-width waveform. Each period is 64 clock slots. A 6-bit brightness level sets how many slots, counted from the start of the period, drive the output high. The duty cycle is (level+1)/64. Level zero therefore still gives a short pulse once per period, and the top level gives a steady high output. The output is fully dark only while the enable bit is cleared.

The level input is copied into a shadow register only at the period boundary, so a write in the middle of a period never shortens or stretches the pulse that is in progress. The output is taken from a flop, which keeps glitches off the pin. With a 13 MHz master clock the output repeats at 203.125 kHz.

Top module: `light_pwm`

## Requirements
- R1: A 6-bit slot counter advances by one on every clock and wraps from 63 to 0, so one period is exactly 64 clocks. Slot 0 of each period is the first clock after the wrap.
- R2: With enable set, exactly level+1 slots of each period drive the output high.
- R3: The high slots are the first ones of the period. The output is high in slot s exactly when s <= level and low in every later slot.
- R4: With enable set and level 0, the output is high in slot 0 only, so one of 64 slots is lit and the output is not dark.
- R5: With enable set and level 63, the output is high in all 64 slots and makes no transitions across periods.
- R6: While enable is cleared, the output stays low in every slot. Enable is sampled on every clock edge.
- R7: The level is sampled only at the edge on which the counter wraps from 63 to 0. A level change at any other time has no effect until the next period.
- R8: A synchronous reset forces the output low and clears both the counter and the shadow level. In the first period after reset the output is therefore low in slots 1 to 63, whatever the level input is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| light_en | input | 1 | Light enable; 0 holds the output low |
| level | input | 6 | Brightness level; the duty cycle is (level+1)/64 |
| pwm_out | output | 1 | Light output |

## Verification
The output comes from a flop that is loaded on the same edge that moves the counter into a slot, so the value for slot s is valid in the half cycle that follows that edge. The bench keeps its own slot number, counting edges from the release of reset, and samples `pwm_out` at each falling edge against that number. A level written in slot 63 takes effect from slot 0 of the next period. The scoreboard holds each period's expected settings until the monitor sees slot 0, and it compares a full period only once slot 63 has been sampled. A changed level is driven in slot 20 of each period, so it is due only at the next boundary, and the same per-period comparison checks that it had no effect before then.

// File: rtl/light_pwm_pkg.sv
package light_pwm_pkg;

  // A slot is lit when its index has not passed the latched level.
  function automatic logic slot_lit(input logic [5:0] slot, input logic [5:0] lvl);
    return (slot <= lvl);
  endfunction

  // Lit slots per period for a given level.
  function automatic int unsigned lit_slots(input int unsigned lvl);
    return lvl + 1;
  endfunction

endpackage

// File: rtl/pwm_slot_counter.sv
module pwm_slot_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  assign wrap    = (cnt_q == LAST);
  assign cnt_nxt = rst ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/pwm_level_shadow.sv
module pwm_level_shadow #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  input  logic [CNT_W-1:0] level,
  output logic [CNT_W-1:0] shadow_q,
  output logic [CNT_W-1:0] shadow_nxt
);
  always_comb begin
    if (rst)       shadow_nxt = '0;
    else if (wrap) shadow_nxt = level;
    else           shadow_nxt = shadow_q;
  end

  always_ff @(posedge clk) begin
    shadow_q <= shadow_nxt;
  end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import light_pwm_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             light_en,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] shadow_nxt,
  output logic             pwm_q
);
  logic lit_nxt;

  assign lit_nxt = slot_lit(6'(cnt_nxt), 6'(shadow_nxt));

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= light_en & lit_nxt;
  end
endmodule

// File: rtl/light_pwm.sv
module light_pwm #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             light_en,
  input  logic [CNT_W-1:0] level,
  output logic             pwm_out
);
  logic [CNT_W-1:0] slot_cnt;
  logic [CNT_W-1:0] slot_nxt;
  logic             period_wrap;
  logic [CNT_W-1:0] shadow_lvl;
  logic [CNT_W-1:0] shadow_nxt;

  pwm_slot_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .cnt_q(slot_cnt), .cnt_nxt(slot_nxt), .wrap(period_wrap)
  );

  pwm_level_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst(rst), .wrap(period_wrap), .level(level),
    .shadow_q(shadow_lvl), .shadow_nxt(shadow_nxt)
  );

  pwm_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .light_en(light_en),
    .cnt_nxt(slot_nxt), .shadow_nxt(shadow_nxt), .pwm_q(pwm_out)
  );
endmodule

// File: rtl/light_pwm_checker.sv
module light_pwm_checker #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             light_en,
  input logic [CNT_W-1:0] level,
  input logic             pwm_out,
  input logic [CNT_W-1:0] slot_cnt,
  input logic [CNT_W-1:0] shadow_lvl,
  input logic             period_wrap
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // R1: the counter steps by one and wraps
  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    (slot_cnt == slot_cnt) |=> (slot_cnt == CNT_W'($past(slot_cnt) + 1'b1)));

  // R7: the shadow holds between boundaries
  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !period_wrap |=> $stable(shadow_lvl));

  // R7: the shadow takes the level at the boundary
  p_shadow_load_r7: assert property (@(posedge clk) disable iff (rst)
    period_wrap |=> (shadow_lvl == $past(level)));

  // R6: disabled means dark
  p_dark_r6: assert property (@(posedge clk) disable iff (rst)
    !light_en |=> !pwm_out);

  // R4: slot 0 is always lit when enabled
  p_first_slot_r4: assert property (@(posedge clk) disable iff (rst)
    (light_en && period_wrap) |=> pwm_out);

  // R5: full level keeps the output high in the following slot
  p_full_r5: assert property (@(posedge clk) disable iff (rst)
    (light_en && shadow_lvl == TOP && !period_wrap) |=> pwm_out);

  // R8: reset clears the output, counter and shadow
  p_reset_r8: assert property (@(posedge clk)
    rst |=> (!pwm_out && slot_cnt == '0 && shadow_lvl == '0));
endmodule

bind light_pwm light_pwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .light_en(light_en), .level(level),
  .pwm_out(pwm_out), .slot_cnt(slot_cnt), .shadow_lvl(shadow_lvl),
  .period_wrap(period_wrap)
);

// File: tb/light_pwm_bench.sv
module light_pwm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       light_en = 1'b1;
  logic [5:0] level = 6'd63;
  logic       pwm_out;

  int checks = 0;
  int bad = 0;
  int unsigned edges = 0;

  typedef struct { bit en; int lvl; } item_t;
  item_t item_q[$];

  light_pwm u_light_pwm (
    .clk(clk), .rst(rst), .light_en(light_en), .level(level), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench slot tracker: value equals the slot entered at the last edge
  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  function automatic int slot_now();
    return int'(edges % SLOTS);
  endfunction

  function automatic string tag_for(item_t it);
    if (!it.en)         return "R6";
    if (it.lvl == 0)    return "R4";
    if (it.lvl == 63)   return "R5";
    return "R2 R7";
  endfunction

  // driver: sets inputs in slot 63, disturbs the level mid-period
  task automatic run_period(input bit en, input int lvl);
    item_t it;
    do @(negedge clk); while (slot_now() != SLOTS-1);
    light_en = en;
    level = 6'(lvl);
    it.en = en;
    it.lvl = lvl;
    item_q.push_back(it);
    do @(negedge clk); while (slot_now() != 20);
    level = 6'((lvl + 29) % SLOTS);
  endtask

  // monitor
  item_t cur;
  bit    active = 0;
  int    hi_cnt = 0;
  int    shape_bad = 0;
  always @(negedge clk) begin
    if (rst) active = 0;
    else begin
      if (slot_now() == 0 && !active && item_q.size() > 0) begin
        cur = item_q.pop_front();
        active = 1;
        hi_cnt = 0;
        shape_bad = 0;
      end
      if (active) begin
        if (pwm_out === 1'b1) hi_cnt++;
        if (pwm_out !== ((cur.en && slot_now() <= cur.lvl) ? 1'b1 : 1'b0)) shape_bad++;
        if (slot_now() == SLOTS-1) begin
          checks++;
          if (hi_cnt != (cur.en ? cur.lvl + 1 : 0)) begin
            bad++;
            $display("FAIL %s level=%0d en=%0d: high slots actual=%0d expected=%0d",
                     tag_for(cur), cur.lvl, cur.en, hi_cnt, cur.en ? cur.lvl + 1 : 0);
          end
          checks++;
          if (shape_bad != 0) begin
            bad++;
            $display("FAIL R1 R3 level=%0d en=%0d: misplaced slots actual=%0d expected=0",
                     cur.lvl, cur.en, shape_bad);
          end
          active = 0;
        end
      end
    end
  end

  task automatic check_low(input string what);
    checks++;
    if (pwm_out !== 1'b0) begin
      bad++;
      $display("FAIL R8 %s: pwm_out actual=%b expected=0", what, pwm_out);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: run actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int lit;
    // R8: output low while reset is held, even at full level
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_low("held in reset");
    end
    rst = 1'b0;

    for (int l = 0; l < SLOTS; l++) run_period(1'b1, l);
    run_period(1'b0, 63);
    run_period(1'b0, 0);
    run_period(1'b1, 63);
    run_period(1'b1, 31);
    repeat (70) @(negedge clk);

    // R8: mid-run reset clears the shadow level
    light_en = 1'b1;
    level = 6'd40;
    rst = 1'b1;
    @(negedge clk);
    check_low("after mid-run reset");
    rst = 1'b0;
    lit = 0;
    for (int i = 1; i < SLOTS; i++) begin
      @(negedge clk);
      if (pwm_out === 1'b1) lit++;
    end
    checks++;
    if (lit != 0) begin
      bad++;
      $display("FAIL R8 first period after reset: high slots actual=%0d expected=0", lit);
    end

    run_period(1'b1, 7);
    repeat (70) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule